// File: doc/BRIEF.md
# LCD panel pin formatter for active-matrix and passive panels

This block sits between a pixel source and the pins of an LCD panel. An external timing generator supplies line-start, frame-start and active-region strobes. The block turns these strobes, together with a stream of pixels arriving over a valid/ready handshake, into the panel's pixel-clock enable, line clock, frame clock, bias/data-enable pin and data bus. It does not count timing and does not make the clock. It only decides, cycle by cycle, what each pin carries.

The same pins mean different things in each mode. In active-matrix (TFT) mode the pixel clock runs without a break and one pixel goes out per clock. The line and frame pins carry the horizontal and vertical sync, and the bias pin works as a data-enable. In the passive modes the block packs pixels into bus words: four or eight monochrome pixels per word, or serialized colour subpixels at two and two-thirds pixels per word. The pixel clock pulses only when a word is complete, and the bias pin flips once per frame so the panel sees no DC bias.

Top module: `lcd_pin_formatter`

## Requirements
- R1: In TFT mode (mode 2'b00) with the LCD enabled, lcd_pclk_en is high on every cycle from the cycle after enable onward.
- R2: In TFT mode each accepted pixel appears unchanged on lcd_data in the following cycle, with lcd_acb high in that cycle. lcd_acb is low after any cycle that accepted no pixel.
- R3: In both modes, while enabled, lcd_lclk and lcd_fclk repeat line_start and frame_start one cycle later.
- R4: in_ready is high exactly when lcd_en and active are both high. A pixel offered while in_ready is low is not taken.
- R5: In 4-pixel mode (mode 2'b01) each word holds the MSB of four pixels in lcd_data[3:0], with the first pixel in bit 3. The upper data bits are zero.
- R6: In 8-pixel mode (mode 2'b10) each word holds the MSB of eight pixels in lcd_data[7:0], with the first pixel in bit 7.
- R7: In colour mode (mode 2'b11) each pixel gives three subpixels, taken in the order R, G, B from bits PIX_W-1, 2*PIX_W/3-1 and PIX_W/3-1. They are serialized MSB-first into 8-bit words, so eight pixels fill exactly three words and the packing wraps.
- R8: In passive modes lcd_pclk_en is high only in the cycle after the pixel that completes a word. lcd_data holds its last word between completions.
- R9: In passive modes lcd_acb toggles in the cycle after each frame_start and holds otherwise. It is low after a period of being disabled.
- R10: While lcd_en is low, every output pin is low in the following cycle, in_ready is low, and any partial word is discarded.
- R11: Gaps in the input (in_valid low or active low) do not disturb packing: no pixel is dropped or duplicated within a word.
- R12: During reset every output pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lcd_en | input | 1 | Enables the panel interface |
| mode | input | 2 | 00 TFT, 01 4-pixel mono, 10 8-pixel mono, 11 colour passive |
| in_valid | input | 1 | Pixel on in_pix is valid |
| in_ready | output | 1 | Formatter takes the pixel this cycle |
| in_pix | input | PIX_W | Input pixel (three equal channels R,G,B from MSB down) |
| line_start | input | 1 | Line strobe from the timing generator |
| frame_start | input | 1 | Frame strobe from the timing generator |
| active | input | 1 | Active-region strobe from the timing generator |
| lcd_pclk_en | output | 1 | Pixel clock enable to the panel |
| lcd_lclk | output | 1 | Line clock / horizontal sync |
| lcd_fclk | output | 1 | Frame clock / vertical sync |
| lcd_acb | output | 1 | Bias toggle (passive) or data enable (TFT) |
| lcd_data | output | PIX_W | Panel data bus |

## Verification
The in-design properties check on every cycle the pin meanings that hold from one cycle to the next: the continuous TFT clock, data-enable and data following each accepted TFT pixel, the sync pins following their strobes, passive clock pulses only when a word completes, the bias pin holding between frames, all pins low when disabled, and the packing count staying below a word. Only the bench scenarios can show that the passive words have the right bit content and order: MSB-first placement, colour subpixel serialization across the three-word wrap, packing that survives gaps, and a partial word discarded when the block is disabled.

// File: rtl/lcdfmt_pkg.sv
package lcdfmt_pkg;
    typedef enum logic [1:0] {
        MODE_TFT   = 2'b00,
        MODE_MONO4 = 2'b01,
        MODE_MONO8 = 2'b10,
        MODE_CSTN  = 2'b11
    } lcd_mode_e;
endpackage

// File: rtl/lcdfmt_packer.sv
module lcdfmt_packer
    import lcdfmt_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int BUS_W = 8,
    parameter int SUB_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       mode,
    input  logic             accept,
    input  logic [PIX_W-1:0] pix,
    output logic             word_vld,
    output logic [BUS_W-1:0] word
);
    localparam int ACC_W = BUS_W + SUB_N;
    localparam int CNT_W = $clog2(ACC_W + 1);
    localparam int R_BIT = PIX_W - 1;
    localparam int G_BIT = 2 * PIX_W / 3 - 1;
    localparam int B_BIT = PIX_W / 3 - 1;
    localparam logic [ACC_W-1:0] ONE = ACC_W'(1);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } pack_s;

    pack_s st_d, st_q;

    logic [ACC_W-1:0] sub_bits, wide, shifted;
    logic [CNT_W-1:0] step, target, sum, rem;

    always_comb begin
        st_d     = st_q;
        word_vld = 1'b0;
        word     = '0;
        sub_bits = '0;
        if (mode == MODE_CSTN) begin
            sub_bits[2:0] = {pix[R_BIT], pix[G_BIT], pix[B_BIT]};
            step          = CNT_W'(SUB_N);
        end else begin
            sub_bits[0] = pix[R_BIT];
            step        = CNT_W'(1);
        end
        target  = (mode == MODE_MONO4) ? CNT_W'(4) : CNT_W'(BUS_W);
        wide    = (st_q.acc << step) | sub_bits;
        sum     = st_q.cnt + step;
        rem     = sum - target;
        shifted = wide >> rem;
        if (!en || mode == MODE_TFT) begin
            st_d = '0;
        end else if (accept) begin
            if (sum >= target) begin
                word_vld = 1'b1;
                word     = shifted[BUS_W-1:0];
                st_d.acc = wide & ((ONE << rem) - ONE);
                st_d.cnt = rem;
            end else begin
                st_d.acc = wide;
                st_d.cnt = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(BUS_W));
endmodule

// File: rtl/lcdfmt_pins.sv
module lcdfmt_pins
    import lcdfmt_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic              accept,
    input  logic [DATA_W-1:0] pix,
    input  logic              word_vld,
    input  logic [BUS_W-1:0]  word,
    input  logic              line_start,
    input  logic              frame_start,
    output logic              pclk_en,
    output logic              lclk,
    output logic              fclk,
    output logic              acb,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              pclk;
        logic              lclk;
        logic              fclk;
        logic              acb;
        logic [DATA_W-1:0] data;
    } pin_s;

    pin_s pin_d, pin_q;
    logic tft;

    always_comb begin
        tft   = (mode == MODE_TFT);
        pin_d = pin_q;
        if (!en) begin
            pin_d = '0;
        end else begin
            pin_d.lclk = line_start;
            pin_d.fclk = frame_start;
            if (tft) begin
                pin_d.pclk = 1'b1;
                pin_d.acb  = accept;
                if (accept) pin_d.data = pix;
            end else begin
                pin_d.pclk = word_vld;
                if (frame_start) pin_d.acb = ~pin_q.acb;
                if (word_vld) begin
                    pin_d.data             = '0;
                    pin_d.data[BUS_W-1:0]  = word;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_d;
    end

    assign pclk_en = pin_q.pclk;
    assign lclk    = pin_q.lclk;
    assign fclk    = pin_q.fclk;
    assign acb     = pin_q.acb;
    assign data    = pin_q.data;

    // R1
    tft_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == MODE_TFT) |=> pclk_en);
    // R2
    tft_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == MODE_TFT && accept) |=> (acb && data == $past(pix)));
    // R3
    sync_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (lclk == $past(line_start) && fclk == $past(frame_start)));
    // R8
    stn_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode != MODE_TFT && !word_vld) |=> !pclk_en);
    // R9
    stn_bias_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode != MODE_TFT && !frame_start) |=> $stable(acb));
    // R10
    off_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pclk_en && !lclk && !fclk && !acb && data == '0));
endmodule

// File: rtl/lcd_pin_formatter.sv
module lcd_pin_formatter
    import lcdfmt_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lcd_en,
    input  logic [1:0]       mode,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             line_start,
    input  logic             frame_start,
    input  logic             active,
    output logic             lcd_pclk_en,
    output logic             lcd_lclk,
    output logic             lcd_fclk,
    output logic             lcd_acb,
    output logic [PIX_W-1:0] lcd_data
);
    logic             accept;
    logic             word_vld;
    logic [BUS_W-1:0] word;

    assign in_ready = lcd_en && active;
    assign accept   = in_valid && in_ready;

    lcdfmt_packer #(.PIX_W(PIX_W), .BUS_W(BUS_W), .SUB_N(3)) i_packer (
        .clk(clk), .rst_n(rst_n), .en(lcd_en), .mode(mode),
        .accept(accept), .pix(in_pix), .word_vld(word_vld), .word(word)
    );

    lcdfmt_pins #(.DATA_W(PIX_W), .BUS_W(BUS_W)) i_pins (
        .clk(clk), .rst_n(rst_n), .en(lcd_en), .mode(mode),
        .accept(accept), .pix(in_pix), .word_vld(word_vld), .word(word),
        .line_start(line_start), .frame_start(frame_start),
        .pclk_en(lcd_pclk_en), .lclk(lcd_lclk), .fclk(lcd_fclk),
        .acb(lcd_acb), .data(lcd_data)
    );

    // R12
    reset_pins_chk: assert property (@(posedge clk)
        !rst_n |-> (!lcd_pclk_en && !lcd_acb && lcd_data == '0));
endmodule

// File: tb/test_lcd_pin_formatter.sv
module test_lcd_pin_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lcd_en = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_pix = '0;
    logic        line_start = 1'b0;
    logic        frame_start = 1'b0;
    logic        active = 1'b0;
    logic        lcd_pclk_en, lcd_lclk, lcd_fclk, lcd_acb;
    logic [11:0] lcd_data;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    lcd_pin_formatter #(.PIX_W(12), .BUS_W(8)) i_lcd_pin_formatter (
        .clk(clk), .rst_n(rst_n), .lcd_en(lcd_en), .mode(mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
        .line_start(line_start), .frame_start(frame_start), .active(active),
        .lcd_pclk_en(lcd_pclk_en), .lcd_lclk(lcd_lclk), .lcd_fclk(lcd_fclk),
        .lcd_acb(lcd_acb), .lcd_data(lcd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, sample 2 ns after the following posedge
    task automatic step(input logic en, input logic v, input logic [11:0] p,
                        input logic act, input logic ls, input logic fs);
        @(negedge clk);
        lcd_en = en; in_valid = v; in_pix = p; active = act;
        line_start = ls; frame_start = fs;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [11:0] mono(input logic b);
        return {b, 11'b0};
    endfunction

    function automatic logic [11:0] rgb(input logic [2:0] c);
        return {c[2], 3'b0, c[1], 3'b0, c[0], 3'b0};
    endfunction

    task automatic restart(input logic [1:0] m);
        step(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        mode = m;
        step(1'b1, 1'b0, '0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic test_reset();
        #5;
        check("R12 pclk", int'(lcd_pclk_en), 0);
        check("R12 acb", int'(lcd_acb), 0);
        check("R12 data", int'(lcd_data), 0);
        check("R12 lclk", int'(lcd_lclk), 0);
    endtask

    task automatic test_tft();
        restart(2'b00);
        check("R1 pclk idle", int'(lcd_pclk_en), 1);
        step(1'b1, 1'b1, 12'hA5C, 1'b1, 1'b0, 1'b0);
        check("R2 data", int'(lcd_data), 'hA5C);
        check("R2 de", int'(lcd_acb), 1);
        step(1'b1, 1'b1, 12'h3F1, 1'b1, 1'b1, 1'b0);
        check("R2 data2", int'(lcd_data), 'h3F1);
        check("R3 hsync", int'(lcd_lclk), 1);
        check("R1 pclk", int'(lcd_pclk_en), 1);
        step(1'b1, 1'b0, 12'h777, 1'b1, 1'b0, 1'b1);
        check("R2 de low", int'(lcd_acb), 0);
        check("R3 hsync low", int'(lcd_lclk), 0);
        check("R3 vsync", int'(lcd_fclk), 1);
        @(negedge clk);
        active = 1'b0; in_valid = 1'b1; #1;
        check("R4 ready off", int'(in_ready), 0);
        active = 1'b1; #1;
        check("R4 ready on", int'(in_ready), 1);
        @(posedge clk); #2;
        step(1'b1, 1'b1, 12'h111, 1'b0, 1'b0, 1'b0);
        check("R4 no take", int'(lcd_acb), 0);
    endtask

    task automatic test_mono4();
        restart(2'b01);
        step(1'b1, 1'b1, mono(1), 1'b1, 1'b0, 1'b0);
        check("R8 no clk 1", int'(lcd_pclk_en), 0);
        step(1'b1, 1'b1, mono(0), 1'b1, 1'b0, 1'b0);
        check("R8 no clk 2", int'(lcd_pclk_en), 0);
        step(1'b1, 1'b0, mono(1), 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, mono(1), 1'b0, 1'b0, 1'b0);
        check("R11 gap", int'(lcd_pclk_en), 0);
        step(1'b1, 1'b1, mono(1), 1'b1, 1'b0, 1'b0);
        check("R8 no clk 3", int'(lcd_pclk_en), 0);
        step(1'b1, 1'b1, mono(1), 1'b1, 1'b0, 1'b0);
        check("R5 clk", int'(lcd_pclk_en), 1);
        check("R5 word", int'(lcd_data), 'h00B);
        step(1'b1, 1'b0, '0, 1'b1, 1'b0, 1'b0);
        check("R8 clk drop", int'(lcd_pclk_en), 0);
        check("R8 hold", int'(lcd_data), 'h00B);
    endtask

    task automatic test_mono8();
        logic [7:0] pat = 8'hD2;
        restart(2'b10);
        for (int i = 7; i >= 0; i--) begin
            step(1'b1, 1'b1, mono(pat[i]), 1'b1, 1'b0, 1'b0);
            if (i > 0) check("R6 no clk", int'(lcd_pclk_en), 0);
        end
        check("R6 clk", int'(lcd_pclk_en), 1);
        check("R6 word", int'(lcd_data), 'h0D2);
    endtask

    task automatic test_colour();
        logic [2:0] px [8] = '{3'b101, 3'b110, 3'b011, 3'b111,
                               3'b000, 3'b100, 3'b010, 3'b001};
        int exp_w [3] = '{'hB9, 'hF1, 'h11};
        int w = 0;
        restart(2'b11);
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b1, rgb(px[i]), 1'b1, 1'b0, 1'b0);
            if (i == 2 || i == 5 || i == 7) begin
                check("R7 clk", int'(lcd_pclk_en), 1);
                check("R7 word", int'(lcd_data), exp_w[w]);
                w++;
            end else begin
                check("R8 colour no clk", int'(lcd_pclk_en), 0);
            end
        end
    endtask

    task automatic test_bias();
        restart(2'b10);
        check("R9 start low", int'(lcd_acb), 0);
        step(1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b1);
        check("R9 toggle", int'(lcd_acb), 1);
        check("R3 fclk", int'(lcd_fclk), 1);
        step(1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b0);
        check("R9 hold", int'(lcd_acb), 1);
        check("R3 lclk", int'(lcd_lclk), 1);
        step(1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b1);
        check("R9 toggle back", int'(lcd_acb), 0);
    endtask

    task automatic test_disable();
        restart(2'b01);
        step(1'b1, 1'b1, mono(1), 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, mono(1), 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        lcd_en = 1'b0; in_valid = 1'b1; active = 1'b1; line_start = 1'b1;
        frame_start = 1'b0; #1;
        check("R10 ready", int'(in_ready), 0);
        @(posedge clk); #2;
        check("R10 pclk", int'(lcd_pclk_en), 0);
        check("R10 acb", int'(lcd_acb), 0);
        check("R10 lclk", int'(lcd_lclk), 0);
        check("R10 data", int'(lcd_data), 0);
        step(1'b1, 1'b0, '0, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, mono(0), 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, mono(1), 1'b1, 1'b0, 1'b0);
        check("R10 partial dropped", int'(lcd_pclk_en), 0);
        step(1'b1, 1'b1, mono(0), 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, mono(1), 1'b1, 1'b0, 1'b0);
        check("R10 fresh clk", int'(lcd_pclk_en), 1);
        check("R10 fresh word", int'(lcd_data), 'h005);
    endtask

    initial begin
        test_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_tft();
        test_mono4();
        test_mono8();
        test_colour();
        test_bias();
        test_disable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule